// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block supervises a host processor that proves it is alive by pulsing a kick line at regular intervals. Between kicks a single up-counter runs from zero. If it reaches the first-stage limit, the block raises a non-maskable interrupt. The interrupt is a warm warning that gives software a chance to save state or diagnose the fault. If no kick arrives before the second-stage limit, measured from the moment the warning was raised, the block drops the warning and raises a hard reset request for the whole system.

Each stage limit is fixed at elaboration. It is given either directly in clock cycles or in milliseconds, which the block converts to cycles using the configured clock frequency in kHz. A run-enable input lets the system pause supervision while it sleeps, without losing the elapsed count. The kick input may be asynchronous; it is synchronised inside the block and acts on its rising edge only.

Top module: `wdog_escalator`

## Requirements
- R1: While `rst_ni` is low, `nmi_o` and `rst_o` are low, the counter is at zero and the block is in the watch stage. Reset assertion is asynchronous. Release passes through a two-flop synchroniser, so counting starts on the third rising clock edge after `rst_ni` rises.
- R2: In the watch stage, with no kick, `nmi_o` rises after exactly T1 enabled clock edges counted from the counter's last return to zero. After a reset release, `nmi_o` is first seen high T1+2 cycles after `rst_ni` rises.
- R3: In the warning stage, the counter restarts from zero when `nmi_o` rises. If no kick arrives, `rst_o` rises after exactly T2 further enabled edges, and `nmi_o` falls on the same edge. The two outputs are never high together.
- R4: Once `rst_o` is high, it stays high and ignores kicks and `run_en_i` until `rst_ni` is driven low.
- R5: A rising edge on `kick_i` in the watch or warning stage clears the counter, drops `nmi_o` and returns the block to the watch stage. If `kick_i` is first sampled high on edge n, the counter is cleared on edge n+2. A kick on the same edge as a timeout takes precedence over the timeout.
- R6: A kick held high counts as one kick only. While `kick_i` stays high, the timeouts of R2 and R3 proceed as if the kick line were idle after its first effect.
- R7: While `run_en_i` is low, the counter and stage hold their values and the outputs do not change. A kick still clears the counter and returns the block to the watch stage.
- R8: With `TIME_MODE` = 0, T1 = `STAGE1_CYCLES` and T2 = `STAGE2_CYCLES`. A value of 0 is treated as 1.
- R9: With `TIME_MODE` = 1, each stage time in ms is rounded down to a multiple of 10 and clamped to the range 50 to 500. The result is multiplied by `CLK_KHZ` to give the cycle count. For example, 57 ms at 2 kHz gives 100 cycles, and 600 ms at 2 kHz gives 1000 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| kick_i | input | 1 | Host alive pulse; may be asynchronous; acts on its rising edge |
| run_en_i | input | 1 | High to let the counter advance; low pauses supervision during sleep |
| nmi_o | output | 1 | First-stage warning, held high until a kick or the hard reset |
| rst_o | output | 1 | Second-stage hard reset request, held until `rst_ni` is low |

## Verification
A wrong count or limit selection shows at the ports as an early or late edge on `nmi_o` or `rst_o`. That edge can be off by as little as one cycle, so every output is compared against an independent cycle-accurate model on every cycle. Corrupted stage state shows either as both outputs high together or as a reset request that falls without a reset; either is visible on the cycle after it happens. Faults in the kick path show as a warning that fails to clear exactly three cycles after the kick is driven, or as a held kick that keeps the watchdog from ever firing. The time-mode conversion is checked through the absolute cycle at which each stage expires, with one instance using rounded and clamped millisecond values.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    STG_WATCH = 2'b00,
    STG_WARN  = 2'b01,
    STG_BITE  = 2'b10
  } stage_e;

  // Rounds the ms value down to a 10 ms step, clamps it to 50..500, then scales by kHz.
  function automatic int unsigned ms_to_cycles(input int unsigned khz, input int unsigned ms);
    int unsigned stepped;
    stepped = (ms / 10) * 10;
    if (stepped < 50)  stepped = 50;
    if (stepped > 500) stepped = 500;
    return khz * stepped;
  endfunction

  function automatic int unsigned pick_timeout(input bit time_mode, input int unsigned cycles,
                                               input int unsigned khz, input int unsigned ms);
    int unsigned t;
    t = time_mode ? ms_to_cycles(khz, ms) : cycles;
    if (t == 0) t = 1;
    return t;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign srst_no = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic kick_pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      logic stage_d;
      if (g == 0) begin : g_first
        assign stage_d = kick_i;
      end else begin : g_rest
        assign stage_d = sync_q[g-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= stage_d;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign kick_pulse_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  assign hit_o    = inc_i & (count_q == last_i);
  assign count_en = clr_i | inc_i;

  always_comb begin
    count_d = count_q;
    if (clr_i || hit_o) count_d = '0;
    else if (inc_i)     count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/wdog_stage_ctrl.sv
module wdog_stage_ctrl
  import wdog_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   kick_pulse_i,
  input  logic   run_en_i,
  input  logic   hit_i,
  output stage_e stage_o,
  output logic   clr_o,
  output logic   inc_o,
  output logic   nmi_o,
  output logic   rst_o
);
  stage_e stage_q, stage_d;
  logic   nmi_q, rst_q;
  logic   bitten;

  assign bitten = (stage_q == STG_BITE);
  assign clr_o  = kick_pulse_i & ~bitten;
  assign inc_o  = run_en_i & ~kick_pulse_i & ~bitten;

  always_comb begin
    stage_d = stage_q;
    case (stage_q)
      STG_WATCH: begin
        if (hit_i) stage_d = STG_WARN;
      end
      STG_WARN: begin
        if (kick_pulse_i) stage_d = STG_WATCH;
        else if (hit_i)   stage_d = STG_BITE;
      end
      STG_BITE: stage_d = STG_BITE;
      default:  stage_d = STG_BITE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= STG_WATCH;
      nmi_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      nmi_q   <= (stage_d == STG_WARN);
      rst_q   <= (stage_d == STG_BITE);
    end
  end

  assign stage_o = stage_q;
  assign nmi_o   = nmi_q;
  assign rst_o   = rst_q;
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
  import wdog_pkg::*;
#(
  parameter bit          TIME_MODE     = 1'b0,
  parameter int unsigned STAGE1_CYCLES = 1000000,
  parameter int unsigned STAGE2_CYCLES = 500000,
  parameter int unsigned CLK_KHZ       = 100000,
  parameter int unsigned STAGE1_MS     = 100,
  parameter int unsigned STAGE2_MS     = 100,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  input  logic run_en_i,
  output logic nmi_o,
  output logic rst_o
);
  localparam int unsigned T1    = pick_timeout(TIME_MODE, STAGE1_CYCLES, CLK_KHZ, STAGE1_MS);
  localparam int unsigned T2    = pick_timeout(TIME_MODE, STAGE2_CYCLES, CLK_KHZ, STAGE2_MS);
  localparam int unsigned TMAX  = max_u(T1, T2);
  localparam int unsigned CNT_W = (TMAX < 2) ? 1 : $clog2(TMAX);
  localparam logic [CNT_W-1:0] LAST1 = CNT_W'(T1 - 1);
  localparam logic [CNT_W-1:0] LAST2 = CNT_W'(T2 - 1);

  logic             srst_n;
  logic             kick_pulse;
  stage_e           stage;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] last;
  logic             cnt_clr, cnt_inc, cnt_hit;

  wdog_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (srst_n)
  );

  wdog_kick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_kick_sync (
    .clk_i        (clk_i),
    .rst_ni       (srst_n),
    .kick_i       (kick_i),
    .kick_pulse_o (kick_pulse)
  );

  assign last = (stage == STG_WARN) ? LAST2 : LAST1;

  wdog_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (srst_n),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .last_i  (last),
    .count_o (count),
    .hit_o   (cnt_hit)
  );

  wdog_stage_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (srst_n),
    .kick_pulse_i (kick_pulse),
    .run_en_i     (run_en_i),
    .hit_i        (cnt_hit),
    .stage_o      (stage),
    .clr_o        (cnt_clr),
    .inc_o        (cnt_inc),
    .nmi_o        (nmi_o),
    .rst_o        (rst_o)
  );
endmodule

// File: rtl/wdog_escalator_chk.sv
module wdog_escalator_chk
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             srst_n,
  input logic             kick_pulse,
  input logic             run_en_i,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] last,
  input logic             nmi_o,
  input logic             rst_o
);
  p_exclusive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !srst_n)
    !(nmi_o && rst_o));

  p_rst_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !srst_n)
    rst_o |=> rst_o);

  p_rst_after_warn_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !srst_n)
    $rose(rst_o) |-> $past(nmi_o));

  p_count_in_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !srst_n)
    count <= last);

  p_pause_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !srst_n)
    (!run_en_i && !kick_pulse) |=> ($stable(count) && $stable(nmi_o) && $stable(rst_o)));

  p_kick_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !srst_n)
    (kick_pulse && !rst_o) |=> (count == '0 && !nmi_o && !rst_o));

  p_kick_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !srst_n)
    kick_pulse |=> !kick_pulse);

  p_warn_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !srst_n)
    $fell(nmi_o) |-> (rst_o || $past(kick_pulse)));
endmodule

bind wdog_escalator wdog_escalator_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .srst_n     (srst_n),
  .kick_pulse (kick_pulse),
  .run_en_i   (run_en_i),
  .count      (count),
  .last       (last),
  .nmi_o      (nmi_o),
  .rst_o      (rst_o)
);

// File: tb/wdog_escalator_test.sv
module wdog_ref #(
  parameter int T1 = 4,
  parameter int T2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic en,
  output logic nmi,
  output logic hard
);
  // Model built from R1..R7: two-cycle release, kick acts two edges after capture.
  logic r1, r2, k1, k2, k3;
  int   cnt, stg;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 <= 0; r2 <= 0; k1 <= 0; k2 <= 0; k3 <= 0; cnt <= 0; stg <= 0;
    end else begin
      r1 <= 1'b1;
      r2 <= r1;
      if (!r2) begin
        k1 <= 0; k2 <= 0; k3 <= 0; cnt <= 0; stg <= 0;
      end else begin
        k1 <= kick; k2 <= k1; k3 <= k2;
        if (stg == 2) begin
          stg <= 2;
        end else if (k2 && !k3) begin
          cnt <= 0; stg <= 0;
        end else if (en) begin
          if (cnt == ((stg == 0) ? T1 : T2) - 1) begin
            cnt <= 0; stg <= stg + 1;
          end else begin
            cnt <= cnt + 1;
          end
        end
      end
    end
  end
  assign nmi  = (stg == 1);
  assign hard = (stg == 2);
endmodule

module wdog_escalator_test;
  localparam int CLK_PERIOD = 10;
  localparam int A_T1 = 40;
  localparam int A_T2 = 25;
  localparam int B_KHZ = 2;
  localparam int B_MS1 = 57;
  localparam int B_MS2 = 600;

  function automatic int exp_ms_cycles(input int khz, input int ms);
    int m;
    m = ms - (ms % 10);
    if (m < 50) m = 50;
    if (m > 500) m = 500;
    return khz * m;
  endfunction

  localparam int B_T1 = exp_ms_cycles(B_KHZ, B_MS1);
  localparam int B_T2 = exp_ms_cycles(B_KHZ, B_MS2);

  logic clk = 1'b0;
  logic rst_n;
  logic kick_a, en_a, kick_b, en_b;
  logic nmi_a, hard_a, nmi_b, hard_b;
  logic e_nmi_a, e_hard_a, e_nmi_b, e_hard_b;
  int   n_chk = 0;
  int   n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_escalator #(.TIME_MODE(1'b0), .STAGE1_CYCLES(A_T1), .STAGE2_CYCLES(A_T2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .kick_i(kick_a), .run_en_i(en_a), .nmi_o(nmi_a), .rst_o(hard_a));

  wdog_escalator #(.TIME_MODE(1'b1), .CLK_KHZ(B_KHZ), .STAGE1_MS(B_MS1), .STAGE2_MS(B_MS2)) uut_ms (
    .clk_i(clk), .rst_ni(rst_n), .kick_i(kick_b), .run_en_i(en_b), .nmi_o(nmi_b), .rst_o(hard_b));

  wdog_ref #(.T1(A_T1), .T2(A_T2)) ref_a (
    .clk(clk), .rst_n(rst_n), .kick(kick_a), .en(en_a), .nmi(e_nmi_a), .hard(e_hard_a));
  wdog_ref #(.T1(B_T1), .T2(B_T2)) ref_b (
    .clk(clk), .rst_n(rst_n), .kick(kick_b), .en(en_b), .nmi(e_nmi_b), .hard(e_hard_b));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Every cycle: compare both instances against the model (R2 warning, R3/R4 hard reset).
  task automatic step();
    @(negedge clk);
    check(nmi_a == e_nmi_a,   "R2 nmi cycle-mode", nmi_a, e_nmi_a);
    check(hard_a == e_hard_a, "R3 rst cycle-mode", hard_a, e_hard_a);
    check(nmi_b == e_nmi_b,   "R9 nmi time-mode", nmi_b, e_nmi_b);
    check(hard_b == e_hard_b, "R9 rst time-mode", hard_b, e_hard_b);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    kick_a = 0; kick_b = 0;
    #1;
    check(!nmi_a && !hard_a && !nmi_b && !hard_b, "R1 outputs low in reset",
          {nmi_a, hard_a, nmi_b, hard_b}, 0);
    step(); step();
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int f_na, f_ha, f_nb, f_hb, seen;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; kick_a = 0; kick_b = 0; en_a = 1; en_b = 1;
    do_reset();

    // Phase 1: idle kick, measure expiry edges (R1, R2, R3, R8, R9)
    f_na = 0; f_ha = 0; f_nb = 0; f_hb = 0;
    for (int i = 1; i <= 1200; i++) begin
      step();
      if (nmi_a && f_na == 0)  f_na = i;
      if (hard_a && f_ha == 0) f_ha = i;
      if (nmi_b && f_nb == 0)  f_nb = i;
      if (hard_b && f_hb == 0) f_hb = i;
    end
    check(f_na == A_T1 + 2, "R2 R8 first warning cycle", f_na, A_T1 + 2);
    check(f_ha == A_T1 + A_T2 + 2, "R3 R8 hard reset cycle", f_ha, A_T1 + A_T2 + 2);
    check(f_nb == B_T1 + 2, "R9 time-mode warning cycle", f_nb, B_T1 + 2);
    check(f_hb == B_T1 + B_T2 + 2, "R9 time-mode reset cycle", f_hb, B_T1 + B_T2 + 2);
    check(nmi_a == 0 && nmi_b == 0, "R3 warning dropped at hard reset", nmi_a + nmi_b, 0);

    // R4: kicks and pause do not release the hard reset
    kick_a = 1; kick_b = 1; en_a = 0;
    repeat (4) step();
    kick_a = 0; kick_b = 0; en_a = 1;
    repeat (10) step();
    check(hard_a && hard_b, "R4 hard reset sticky after kick", hard_a + hard_b, 2);

    // R5: single-cycle kick during warning
    do_reset();
    seen = 0;
    while (!nmi_a) step();
    kick_a = 1; step(); kick_a = 0;
    check(nmi_a == 1, "R5 warning still high one cycle after kick", nmi_a, 1);
    step();
    check(nmi_a == 1, "R5 warning still high two cycles after kick", nmi_a, 1);
    step();
    check(nmi_a == 0, "R5 warning cleared three cycles after kick", nmi_a, 0);
    for (int i = 1; i <= A_T1 + 5; i++) begin
      step();
      if (nmi_a && seen == 0) seen = i;
    end
    check(seen == A_T1, "R5 restart from zero after kick", seen, A_T1);

    // R6: kick held high counts once
    do_reset();
    kick_a = 1;
    repeat (100) step();
    check(nmi_a == 1 || hard_a == 1, "R6 held kick does not keep restarting", nmi_a | hard_a, 1);
    kick_a = 0;

    // R7: pause freezes progress; kick still acts while paused
    do_reset();
    en_a = 0;
    repeat (300) step();
    check(nmi_a == 0, "R7 no warning while paused", nmi_a, 0);
    en_a = 1;
    seen = 0;
    for (int i = 1; i <= A_T1 + 5; i++) begin
      step();
      if (nmi_a && seen == 0) seen = i;
    end
    check(seen == A_T1, "R7 count resumes after pause", seen, A_T1);
    en_a = 0;
    kick_a = 1; step(); kick_a = 0; step(); step();
    check(nmi_a == 0, "R7 kick clears warning while paused", nmi_a, 0);
    en_a = 1;

    // Random phase compared against the model each cycle
    for (int seg = 0; seg < 120; seg++) begin
      int gap, hold;
      gap  = $urandom_range(10, 90);
      hold = $urandom_range(1, 4);
      for (int i = 0; i < gap; i++) begin
        en_a = ($urandom_range(0, 9) != 0);
        step();
      end
      kick_a = 1;
      for (int i = 0; i < hold; i++) step();
      kick_a = 0;
      if (hard_a && $urandom_range(0, 1) == 1) begin
        en_a = 1;
        do_reset();
      end
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule